// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire synchronous link: a serial clock, a transmit data line and a receive data line. Software reaches it through a small register port. It writes a byte to the transmit buffer, and the block copies that byte into a shift register as soon as the shifter is idle. The byte then leaves least significant bit first, and the incoming line is collected into a receive buffer at the same time. A transfer in either direction starts only from a write to the transmit buffer. To receive, software enables both directions and writes a dummy byte, and that dummy byte is what appears on the transmit line.

The serial clock has two sources. It can come from an internal divider, which is driven onto the clock pin. It can also come from an external clock input, which is synchronised into the core clock domain. A pin-enable control decides whether the block drives its pins or hands them back to general-purpose I/O. This control only gates the output enables, so a transfer already in progress keeps shifting internally while the pins are released.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, the status word reads 0x03 (bit 0 = transmit buffer empty, bit 1 = shift done, bit 2 = receive full). The transmit line is high, the clock output is high, and both output enables are low.
- R2: A frame moves 8 bits, least significant bit first. Each bit is placed on the transmit line at a falling serial clock edge, and the receive line is sampled at the following rising edge. With the internal clock, each half period lasts DIV_HALF core cycles.
- R3: A write to address 0 loads the transmit buffer. When the transmit enable (control bit 0) is set and the shifter is idle, the buffer moves into the shifter on the next cycle. In that cycle the empty flag sets and the shift-done flag clears. With the internal clock, the shift-done flag sets 16*DIV_HALF cycles after the load.
- R4: With the internal clock selected (control bit 3 = 0), the clock output enable equals the pin enable (control bit 2). The clock output rests high whenever no frame is shifting.
- R5: After a frame, the transmit line keeps the level of the last bit sent until the next frame shifts.
- R6: A byte is captured into the receive buffer, and the receive-full flag set, only when the receive enable (control bit 1) was set at the start of the frame and is still set at its end. No frame starts while the transmit enable is clear, so a buffer write with only the receive enable set leaves the clock idle.
- R7: Reading address 0 returns the receive buffer and clears the receive-full flag.
- R8: Clearing the pin enable drops both output enables on the next cycle, but the frame keeps shifting and completes at its normal time. A buffer write while the pins are released still starts a frame, and setting the pin enable mid-frame drives the pins at once.
- R9: With the external clock selected (control bit 3 = 1), a buffer write is ignored while the synchronised clock input is low. Setting the transmit enable from clear is also ignored while that input is low.
- R10: With the external clock, a buffer write only arms the shifter, and nothing shifts until the clock input falls. The frame completes after the eighth rising edge of the clock input.
- R11: Clearing the transmit and receive enables together mid-frame aborts the frame. The clock output returns high within two cycles, and neither the shift-done flag nor the receive-full flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive-full on address 0) |
| bus_addr | input | 1 | 0 = data buffers, 1 = control (write) / status (read) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data: receive buffer or status word |
| sclk_in | input | 1 | External serial clock input |
| sclk_out | output | 1 | Internal serial clock level |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| rxd | input | 1 | Serial receive data |
| txd_out | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Output enable for the transmit data pin |

## Verification
With the internal clock, a buffer write sampled at edge E0 loads the shifter at E0+1, and shift-done is due exactly at E0+1+16*DIV_HALF. The bench checks the flag to be clear one cycle before that point and set at it. Status reads are combinational, so every check samples on the falling core edge after the register update it expects. With the external clock, the work is counted in serial clock edges rather than core cycles. The bench checks that nothing completes while no clock edges arrive, then samples the flags after the eighth rising edge plus the synchroniser delay. Serial data is compared through a bench-side peer that drives the receive line on falling serial edges and captures the transmit line on rising ones.

// File: rtl/sser_pkg.sv
package sser_pkg;
   // register addresses
   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;
   // control bit positions
   localparam int CB_TX  = 0;
   localparam int CB_RX  = 1;
   localparam int CB_PIN = 2;
   localparam int CB_EXT = 3;
   // status bit positions
   localparam int SB_EMPTY = 0;
   localparam int SB_DONE  = 1;
   localparam int SB_FULL  = 2;

   typedef struct packed {
      logic ext_clk;
      logic pin_en;
      logic rx_en;
      logic tx_en;
   } sser_ctl_t;
endpackage

// File: rtl/sser_clkgen.sv
module sser_clkgen #(
   parameter int DIV_HALF    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int EXT_CLK_EN  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ext_sel,
   input  logic sclk_in,
   output logic sclk_int,
   output logic sclk_in_hi,
   output logic fall_tick,
   output logic rise_tick
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   if (DIV_HALF < 1) begin : g_bad_div
      $error("sser_clkgen: DIV_HALF must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("sser_clkgen: SYNC_STAGES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          int_expire;
   logic          ext_fall;
   logic          ext_rise;

   assign int_expire = run && !ext_sel && (cnt_q == CW'(DIV_HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         sclk_int <= 1'b1;
      end else if (!run || ext_sel) begin
         cnt_q    <= '0;
         sclk_int <= 1'b1;
      end else if (int_expire) begin
         cnt_q    <= '0;
         sclk_int <= ~sclk_int;
      end else begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   if (EXT_CLK_EN != 0) begin : g_ext
      logic [SYNC_STAGES:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-1:0], sclk_in};
      end
      assign sclk_in_hi = sync_q[SYNC_STAGES-1];
      assign ext_fall   =  sync_q[SYNC_STAGES] && !sync_q[SYNC_STAGES-1];
      assign ext_rise   = !sync_q[SYNC_STAGES] &&  sync_q[SYNC_STAGES-1];
   end else begin : g_no_ext
      logic unused_in;
      assign unused_in  = sclk_in;
      assign sclk_in_hi = 1'b1;
      assign ext_fall   = 1'b0;
      assign ext_rise   = 1'b0;
   end

   assign fall_tick = run && (ext_sel ? ext_fall : (int_expire &&  sclk_int));
   assign rise_tick = run && (ext_sel ? ext_rise : (int_expire && !sclk_int));
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              abort,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rx_arm,
   input  logic              fall_tick,
   input  logic              rise_tick,
   input  logic              rxd,
   output logic              busy,
   output logic              txd,
   output logic              armed,
   output logic              last_rise,
   output logic [DATA_W-1:0] rx_next
);
   localparam int CW = $clog2(DATA_W + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("sser_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [CW-1:0]     nfall;
   logic [CW-1:0]     nrise;
   logic              fall_ok;
   logic              rise_ok;

   // a fall is taken only when every earlier fall has been matched by a rise
   assign fall_ok   = busy && fall_tick && (nfall == nrise) && (nfall < CW'(DATA_W));
   assign rise_ok   = busy && rise_tick && (nfall != nrise);
   assign last_rise = rise_ok && (nrise == CW'(DATA_W - 1));
   assign rx_next   = {rxd, rx_sr[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         txd   <= 1'b1;
         armed <= 1'b0;
         tx_sr <= '0;
         rx_sr <= '0;
         nfall <= '0;
         nrise <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         armed <= 1'b0;
      end else if (load) begin
         busy  <= 1'b1;
         armed <= rx_arm;
         tx_sr <= load_data;
         nfall <= '0;
         nrise <= '0;
      end else begin
         if (fall_ok) begin
            txd   <= tx_sr[0];
            tx_sr <= {1'b0, tx_sr[DATA_W-1:1]};
            nfall <= nfall + 1'b1;
         end
         if (rise_ok) begin
            rx_sr <= rx_next;
            nrise <= nrise + 1'b1;
            if (last_rise) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
   import sser_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_HALF    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int EXT_CLK_EN  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   input  logic              rxd,
   output logic              txd_out,
   output logic              txd_oe
);
   if (DATA_W < 4) begin : g_bad_width
      $error("sync_serial_xcvr: DATA_W must hold the 4 control bits");
   end

   sser_ctl_t         ctl_q;
   logic [DATA_W-1:0] tbuf_q;
   logic [DATA_W-1:0] rbuf_q;
   logic              tbuf_full;
   logic              rx_full;
   logic              shift_done;

   logic              ext_mode;
   logic              sclk_in_hi;
   logic              fall_tick;
   logic              rise_tick;
   logic              busy;
   logic              armed;
   logic              last_rise;
   logic [DATA_W-1:0] rx_next;
   logic              data_wr;
   logic              data_wr_ok;
   logic              ctrl_wr;
   logic              rd_data;
   logic              load;
   logic              abort;
   logic              rx_capture;
   logic              ext_new;
   logic              tx_take;

   assign ext_mode   = (EXT_CLK_EN != 0) && ctl_q.ext_clk;
   assign data_wr    = bus_wr && (bus_addr == ADDR_DATA);
   assign ctrl_wr    = bus_wr && (bus_addr == ADDR_CTRL);
   assign rd_data    = bus_rd && (bus_addr == ADDR_DATA);
   // with an external clock, buffer writes land only while the clock input is high
   assign data_wr_ok = data_wr && (!ext_mode || sclk_in_hi);
   assign load       = tbuf_full && ctl_q.tx_en && !busy;
   assign abort      = busy && !ctl_q.tx_en;
   assign rx_capture = last_rise && armed && ctl_q.rx_en;
   assign ext_new    = (EXT_CLK_EN != 0) && bus_wdata[CB_EXT];
   assign tx_take    = bus_wdata[CB_TX] && (ctl_q.tx_en || !ext_new || sclk_in_hi);

   sser_clkgen #(
      .DIV_HALF   (DIV_HALF),
      .SYNC_STAGES(SYNC_STAGES),
      .EXT_CLK_EN (EXT_CLK_EN)
   ) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .ext_sel   (ext_mode),
      .sclk_in   (sclk_in),
      .sclk_int  (sclk_out),
      .sclk_in_hi(sclk_in_hi),
      .fall_tick (fall_tick),
      .rise_tick (rise_tick)
   );

   sser_shifter #(
      .DATA_W(DATA_W)
   ) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .abort    (abort),
      .load_data(tbuf_q),
      .rx_arm   (ctl_q.rx_en),
      .fall_tick(fall_tick),
      .rise_tick(rise_tick),
      .rxd      (rxd),
      .busy     (busy),
      .txd      (txd_out),
      .armed    (armed),
      .last_rise(last_rise),
      .rx_next  (rx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         tbuf_q     <= '0;
         tbuf_full  <= 1'b0;
         rbuf_q     <= '0;
         rx_full    <= 1'b0;
         shift_done <= 1'b1;
      end else begin
         if (ctrl_wr) begin
            ctl_q.tx_en   <= tx_take;
            ctl_q.rx_en   <= bus_wdata[CB_RX];
            ctl_q.pin_en  <= bus_wdata[CB_PIN];
            ctl_q.ext_clk <= ext_new;
         end
         if (data_wr_ok) begin
            tbuf_q    <= bus_wdata;
            tbuf_full <= 1'b1;
         end else if (load) begin
            tbuf_full <= 1'b0;
         end
         if (load)           shift_done <= 1'b0;
         else if (last_rise) shift_done <= 1'b1;
         if (rx_capture) begin
            rbuf_q  <= rx_next;
            rx_full <= 1'b1;
         end else if (rd_data) begin
            rx_full <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_DATA) begin
         bus_rdata = rbuf_q;
      end else begin
         bus_rdata[SB_EMPTY] = !tbuf_full;
         bus_rdata[SB_DONE]  = shift_done;
         bus_rdata[SB_FULL]  = rx_full;
      end
   end

   assign txd_oe  = ctl_q.pin_en && ctl_q.tx_en;
   assign sclk_oe = ctl_q.pin_en && !ext_mode;
endmodule

// File: rtl/sser_chk.sv
module sser_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic load,
   input logic data_wr_ok,
   input logic tbuf_full,
   input logic txd_out,
   input logic sclk_out,
   input logic sclk_oe,
   input logic txd_oe,
   input logic pin_wr_off,
   input logic rd_data,
   input logic rx_capture,
   input logic rx_full
);
   // R5
   txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> $stable(txd_out));

   // R4
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> sclk_out);

   // R8
   pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_wr_off |=> (!txd_oe && !sclk_oe));

   // R3
   empty_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !data_wr_ok) |=> !tbuf_full);

   // R7
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_capture) |=> !rx_full);

   // R3
   busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);
endmodule

bind sync_serial_xcvr sser_chk u_sser_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .load      (load),
   .data_wr_ok(data_wr_ok),
   .tbuf_full (tbuf_full),
   .txd_out   (txd_out),
   .sclk_out  (sclk_out),
   .sclk_oe   (sclk_oe),
   .txd_oe    (txd_oe),
   .pin_wr_off(ctrl_wr && !bus_wdata[2]),
   .rd_data   (rd_data),
   .rx_capture(rx_capture),
   .rx_full   (rx_full)
);

// File: tb/tb_sync_serial_xcvr.sv
`timescale 1ns/1ps
module tb_sync_serial_xcvr;
   localparam int DW  = 8;
   localparam int DIV = 2;
   localparam int EXT_HALF = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic          bus_addr = 1'b1;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          sclk_in = 1'b1;
   logic          sclk_out;
   logic          sclk_oe;
   logic          rxd = 1'b1;
   logic          txd_out;
   logic          txd_oe;

   int            n_tests = 0;
   int            n_fail  = 0;
   bit            finished = 1'b0;

   sync_serial_xcvr #(.DATA_W(DW), .DIV_HALF(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
      .rxd(rxd), .txd_out(txd_out), .txd_oe(txd_oe)
   );

   always #5 clk = ~clk;

   // serial peer: drives rxd on falling serial edges, captures txd on rising ones
   bit            use_ext = 1'b0;
   logic [DW-1:0] peer_tx = '0;
   logic [DW-1:0] peer_rx = '0;
   int            peer_idx = 0;
   wire           sclk_bus = use_ext ? sclk_in : sclk_out;

   always @(negedge sclk_bus) begin
      if (peer_idx < DW) rxd = peer_tx[peer_idx];
      peer_idx++;
   end
   always @(posedge sclk_bus) peer_rx = {txd_out, peer_rx[DW-1:1]};

   function automatic logic [DW-1:0] stat_word(bit empty, bit done, bit full);
      stat_word = '0;
      stat_word[0] = empty;
      stat_word[1] = done;
      stat_word[2] = full;
   endfunction

   function automatic logic ctl_word_bit(logic [DW-1:0] b, int i);
      ctl_word_bit = b[i];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic a, logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 1'b1;
   endtask

   task automatic rd_stat(output logic [DW-1:0] v);
      bus_addr = 1'b1;
      #1 v = bus_rdata;
   endtask

   task automatic rd_rx(output logic [DW-1:0] v);
      @(negedge clk);
      bus_addr = 1'b0; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = 1'b1;
   endtask

   task automatic peer_start(logic [DW-1:0] b);
      peer_tx = b; peer_idx = 0; peer_rx = '0;
   endtask

   // internal-clock frame with exact flag timing
   task automatic timed_frame(string req, logic [DW-1:0] d);
      logic [DW-1:0] s;
      wr(1'b0, d);
      rd_stat(s); chk({req, " empty clear before load"}, s[0], 1'b0);
      cyc(1);
      rd_stat(s); chk({req, " empty set at load (R3)"}, s[0], 1'b1);
      chk({req, " done clear at load (R3)"}, s[1], 1'b0);
      cyc(16*DIV - 1);
      rd_stat(s); chk({req, " done still clear one cycle early (R3)"}, s[1], 1'b0);
      cyc(1);
      rd_stat(s); chk({req, " done set on time (R3)"}, s[1], 1'b1);
   endtask

   task automatic ext_pulses(int n);
      for (int i = 0; i < n; i++) begin
         sclk_in = 1'b0; cyc(EXT_HALF);
         sclk_in = 1'b1; cyc(EXT_HALF);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] s;
      logic [DW-1:0] r;
      logic [DW-1:0] t;
      logic [DW-1:0] p;
      void'($urandom(32'd20240611));
      cyc(5);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd_stat(s);
      chk("R1 status", s, stat_word(1, 1, 0));
      chk("R1 txd", txd_out, 1'b1);
      chk("R1 sclk", sclk_out, 1'b1);
      chk("R1 oes", {txd_oe, sclk_oe}, 2'b00);

      // R2 R3 R4 R5 internal transmit only
      wr(1'b1, 8'h05);
      peer_start(8'h00);
      timed_frame("R2", 8'hA6);
      chk("R2 lsb-first byte", peer_rx, 8'hA6);
      chk("R4 sclk idle high", sclk_out, 1'b1);
      chk("R4 sclk_oe internal", sclk_oe, 1'b1);
      chk("R5 txd holds bit7", txd_out, ctl_word_bit(8'hA6, 7));
      cyc(10);
      chk("R5 txd still held", txd_out, ctl_word_bit(8'hA6, 7));
      rd_stat(s); chk("R6 no capture without rx enable", s[2], 1'b0);
      peer_start(8'h00);
      timed_frame("R5b", 8'h35);
      chk("R5 txd holds bit7 low", txd_out, ctl_word_bit(8'h35, 7));

      // R6 R7 receive with dummy write
      wr(1'b1, 8'h07);
      peer_start(8'h5C);
      timed_frame("R6", 8'h81);
      rd_stat(s); chk("R6 rx full", s[2], 1'b1);
      chk("R6 dummy on txd", peer_rx, 8'h81);
      rd_rx(r);
      chk("R6 rx byte", r, 8'h5C);
      rd_stat(s); chk("R7 rx full cleared by read", s[2], 1'b0);

      // R6 no start with receive enable only
      wr(1'b1, 8'h06);
      wr(1'b0, 8'h11);
      cyc(20*DIV);
      rd_stat(s); chk("R6 no frame without tx enable", s, stat_word(0, 1, 0));
      chk("R6 sclk idle", sclk_out, 1'b1);
      peer_start(8'h00);
      wr(1'b1, 8'h07);      // pending byte now starts
      cyc(16*DIV + 4);
      rd_rx(r);

      // R8 pins released, shifting continues
      wr(1'b1, 8'h03);
      chk("R8 oes off", {txd_oe, sclk_oe}, 2'b00);
      peer_start(8'hC3);
      timed_frame("R8", 8'h5A);
      chk("R8 oes still off", {txd_oe, sclk_oe}, 2'b00);
      rd_rx(r);
      chk("R8 internal rx continued", r, 8'hC3);
      peer_start(8'h00);
      wr(1'b0, 8'hF0);
      cyc(4*DIV);
      wr(1'b1, 8'h07);
      chk("R8 pins driven mid-frame", {txd_oe, sclk_oe}, 2'b11);
      cyc(16*DIV);
      wr(1'b0, 8'h99);
      cyc(3*DIV);
      wr(1'b1, 8'h03);
      chk("R8 pins released mid-frame", {txd_oe, sclk_oe}, 2'b00);
      cyc(16*DIV);
      rd_stat(s); chk("R8 frame completed after release", s[1], 1'b1);
      rd_rx(r);

      // R9 R10 external clock
      use_ext = 1'b1;
      wr(1'b1, 8'h0F);
      chk("R4 sclk_oe off in external mode", sclk_oe, 1'b0);
      sclk_in = 1'b0; cyc(5);
      wr(1'b0, 8'h77);
      cyc(2);
      rd_stat(s); chk("R9 write ignored while clock low", s[0], 1'b1);
      sclk_in = 1'b1; cyc(5);
      peer_start(8'h96);
      wr(1'b0, 8'h3C);
      cyc(2);
      rd_stat(s); chk("R10 armed: empty and not done", s[1:0], 2'b01);
      t = txd_out;
      cyc(30);
      rd_stat(s); chk("R10 no shift without clock", s[1], 1'b0);
      chk("R10 txd unchanged while armed", txd_out, t);
      ext_pulses(7);
      rd_stat(s); chk("R10 not done after 7 edges", s[1], 1'b0);
      ext_pulses(1);
      rd_stat(s); chk("R10 done after 8 edges", s[1], 1'b1);
      chk("R10 tx byte", peer_rx, 8'h3C);
      rd_rx(r);
      chk("R10 rx byte", r, 8'h96);
      // R9 transmit enable set while clock low is ignored
      wr(1'b1, 8'h0E);
      wr(1'b0, 8'h55);
      sclk_in = 1'b0; cyc(5);
      wr(1'b1, 8'h0F);
      sclk_in = 1'b1; cyc(5);
      rd_stat(s); chk("R9 tx enable ignored while clock low", s[0], 1'b0);
      wr(1'b1, 8'h0F);
      cyc(2);
      rd_stat(s); chk("R9 tx enable taken while clock high", s[0], 1'b1);
      peer_start(8'h00);
      ext_pulses(8);
      rd_rx(r);
      use_ext = 1'b0;

      // R11 abort
      wr(1'b1, 8'h07);
      wr(1'b0, 8'hFF);
      cyc(5*DIV);
      wr(1'b1, 8'h04);
      cyc(2);
      chk("R11 sclk high after abort", sclk_out, 1'b1);
      cyc(16*DIV);
      rd_stat(s); chk("R11 no done/full after abort", s[2:1], 2'b00);

      // R2 R6 random frames
      wr(1'b1, 8'h07);
      for (int i = 0; i < 20; i++) begin
         t = 8'($urandom);
         p = 8'($urandom);
         peer_start(p);
         timed_frame("R2 random", t);
         chk("R2 random tx", peer_rx, t);
         rd_rx(r);
         chk("R6 random rx", r, p);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule